// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block computes the eight integer multiply, divide and remainder operations of the RISC-V M extension one bit-step at a time, with no hardware multiplier. It is meant for small FPGAs that have no DSP slices, where a few hundred LUTs and a loop of several dozen cycles is preferred over a wide array multiplier.

A caller raises `start_i` for one cycle with a 3-bit operation code and two 32-bit operands. The unit takes the absolute values of signed operands, runs a shift-add loop (multiply) or a restoring shift-subtract loop (divide) for a fixed number of cycles, then corrects the sign. It returns the result with a single-cycle `done_o`. Two parameters set how many bit-steps are chained combinationally per clock, one for each loop, which trades latency against logic depth. Two further parameters remove the multiply or the divide datapath entirely.

Top module: `iter_muldiv`

## Requirements
- R1: `op_i` = 0 (MUL) returns the low 32 bits of the product; the code values are fixed as 0 MUL, 1 MULH, 2 MULHSU, 3 MULHU, 4 DIV, 5 DIVU, 6 REM, 7 REMU.
- R2: MULH treats both operands as signed, MULHSU treats `a_i` as signed and `b_i` as unsigned, MULHU treats both as unsigned; each returns bits 63..32 of the 64-bit product.
- R3: DIV (signed) and DIVU (unsigned) return the quotient rounded toward zero.
- R4: REM (signed) and REMU (unsigned) return the remainder, which for REM takes the sign of the dividend.
- R5: With `b_i` = 0, DIV and DIVU return all ones, and REM and REMU return `a_i` unchanged.
- R6: For `a_i` = 0x80000000 and `b_i` = 0xFFFFFFFF, DIV returns 0x80000000 and REM returns 0.
- R7: A multiply operation raises `done_o` exactly 32/MUL_STEPS clock edges after the edge that accepts the start.
- R8: A divide or remainder operation raises `done_o` exactly 32/DIV_STEPS + 1 clock edges after the accepting edge.
- R9: `done_o` is high for exactly one cycle per operation, and `result_o` does not change while `done_o` is low.
- R10: A start request seen while `busy_o` is high is ignored: the running operation finishes with its own result and latency.
- R11: After reset `busy_o`, `done_o` and `result_o` are all zero.
- R12: An operation whose datapath is disabled by MUL_EN or DIV_EN returns zero, with `done_o` one clock edge after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted when not busy |
| op_i | input | 3 | Operation code (see R1) |
| a_i | input | 32 | First operand / dividend |
| b_i | input | 32 | Second operand / divisor |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Result, held until the next completion |

## Verification
The bench builds two copies: one with the default parameters (one bit-step per cycle in both loops, both datapaths present), which exercises the full 32- and 33-cycle loops and all eight operations against a 64-bit reference model, and one with multiply removed, four multiply steps and eight divide steps per cycle, which brings the disabled-path zero result and the shortened 5-cycle divide within reach. Random operands are skewed toward zero, all-ones, the most negative value and small numbers so that the divide-by-zero and overflow rules are hit repeatedly, besides the directed cases.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } mdu_op_e;

  function automatic logic op_is_div(input mdu_op_e op);
    return op[2];
  endfunction

  function automatic logic op_wants_rem(input mdu_op_e op);
    return op[1];
  endfunction

  function automatic logic op_a_signed(input mdu_op_e op);
    return (op == OP_MULH) || (op == OP_MULHSU) || (op == OP_DIV) || (op == OP_REM);
  endfunction

  function automatic logic op_b_signed(input mdu_op_e op);
    return (op == OP_MULH) || (op == OP_DIV) || (op == OP_REM);
  endfunction

endpackage

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
  parameter int W     = 32,
  parameter int STEPS = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_nxt_o
);

  logic [W-1:0] hi_q, lo_q, mc_q;
  logic [W-1:0] hi_c, lo_c;

  // one shift-add bit-step: add multiplicand if lsb set, shift pair right
  function automatic logic [2*W-1:0] add_shift(input logic [W-1:0] hi,
                                               input logic [W-1:0] lo,
                                               input logic [W-1:0] mc);
    logic [W:0] sum;
    sum = {1'b0, hi} + (lo[0] ? {1'b0, mc} : '0);
    return {sum, lo[W-1:1]};
  endfunction

  always_comb begin
    hi_c = hi_q;
    lo_c = lo_q;
    for (int k = 0; k < STEPS; k++) begin
      {hi_c, lo_c} = add_shift(hi_c, lo_c, mc_q);
    end
  end

  assign prod_nxt_o = {hi_c, lo_c};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      mc_q <= '0;
    end else if (load_i) begin
      hi_q <= '0;
      lo_q <= mplier_i;
      mc_q <= mcand_i;
    end else if (step_i) begin
      hi_q <= hi_c;
      lo_q <= lo_c;
    end
  end

endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
  parameter int W     = 32,
  parameter int STEPS = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);

  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic [W-1:0] rem_c, quo_c;

  // one restoring bit-step: shift in next dividend bit, subtract if it fits
  function automatic logic [2*W-1:0] sub_shift(input logic [W-1:0] rem,
                                               input logic [W-1:0] quo,
                                               input logic [W-1:0] dvs);
    logic [W:0] sh, diff;
    logic       fits;
    sh   = {rem, quo[W-1]};
    diff = sh - {1'b0, dvs};
    fits = (sh >= {1'b0, dvs});
    return {(fits ? diff[W-1:0] : sh[W-1:0]), quo[W-2:0], fits};
  endfunction

  always_comb begin
    rem_c = rem_q;
    quo_c = quo_q;
    for (int k = 0; k < STEPS; k++) begin
      {rem_c, quo_c} = sub_shift(rem_c, quo_c, dvs_q);
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= dvd_i;
      dvs_q <= dvs_i;
    end else if (step_i) begin
      rem_q <= rem_c;
      quo_q <= quo_c;
    end
  end

  // partial remainder never reaches the divisor (R3)
  p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs_q != '0) |-> (rem_q < dvs_q))
    else $error("partial remainder not below divisor");

endmodule

// File: rtl/iter_muldiv.sv
module iter_muldiv
  import mdu_pkg::*;
#(
  parameter int W         = 32,
  parameter int MUL_STEPS = 1,
  parameter int DIV_STEPS = 1,
  parameter bit MUL_EN    = 1'b1,
  parameter bit DIV_EN    = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);

  localparam int MUL_CYC = W / MUL_STEPS;
  localparam int DIV_CYC = W / DIV_STEPS;
  localparam int CW      = $clog2(W + 2) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  st_e          st_q;
  logic [CW-1:0] cnt_q;
  mdu_op_e      op_q;
  logic         neg_a_q, neg_b_q, bzero_q, off_q;
  logic [W-1:0] a_q;
  logic         done_q;
  logic [W-1:0] res_q;

  // named internal events
  mdu_op_e      op_in;
  logic         accept, in_div, in_off, sa, sb;
  logic [W-1:0] mag_a, mag_b;
  logic         load_mul, load_div, step_mul, step_div, last_run;
  logic [2*W-1:0] prod_nxt;
  logic [W-1:0] quo, rem, mul_res, div_res;

  function automatic logic [W-1:0] fix_mul(input logic [2*W-1:0] p,
                                           input logic neg, input logic upper);
    logic [2*W-1:0] s;
    s = neg ? -p : p;
    return upper ? s[2*W-1:W] : s[W-1:0];
  endfunction

  function automatic logic [W-1:0] fix_div(input logic [W-1:0] q, input logic [W-1:0] r,
                                           input logic na, input logic nb, input logic bz,
                                           input logic [W-1:0] dvd, input logic want_rem);
    if (bz) return want_rem ? dvd : '1;
    if (want_rem) return na ? -r : r;
    return (na ^ nb) ? -q : q;
  endfunction

  assign op_in    = mdu_op_e'(op_i);
  assign accept   = start_i && (st_q == ST_IDLE);
  assign in_div   = op_is_div(op_in);
  assign in_off   = in_div ? !DIV_EN : !MUL_EN;
  assign sa       = op_a_signed(op_in) && a_i[W-1];
  assign sb       = op_b_signed(op_in) && b_i[W-1];
  assign mag_a    = sa ? -a_i : a_i;
  assign mag_b    = sb ? -b_i : b_i;
  assign load_mul = accept && !in_div && !in_off;
  assign load_div = accept && in_div && !in_off;
  assign step_mul = (st_q == ST_RUN) && !op_is_div(op_q);
  assign step_div = (st_q == ST_RUN) && op_is_div(op_q);
  assign last_run = (st_q == ST_RUN) && (cnt_q == CW'(1));

  generate
    if (MUL_EN) begin : g_mul
      mdu_mul_core #(.W(W), .STEPS(MUL_STEPS)) u_mul (
        .clk(clk), .rst_n(rst_n), .load_i(load_mul), .step_i(step_mul),
        .mcand_i(mag_a), .mplier_i(mag_b), .prod_nxt_o(prod_nxt));
    end else begin : g_no_mul
      assign prod_nxt = '0;
    end
    if (DIV_EN) begin : g_div
      mdu_div_core #(.W(W), .STEPS(DIV_STEPS)) u_div (
        .clk(clk), .rst_n(rst_n), .load_i(load_div), .step_i(step_div),
        .dvd_i(mag_a), .dvs_i(mag_b), .quo_o(quo), .rem_o(rem));
    end else begin : g_no_div
      assign quo = '0;
      assign rem = '0;
    end
  endgenerate

  assign mul_res = fix_mul(prod_nxt, neg_a_q ^ neg_b_q, op_q != OP_MUL);
  assign div_res = fix_div(quo, rem, neg_a_q, neg_b_q, bzero_q, a_q, op_wants_rem(op_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_MUL;
      neg_a_q <= 1'b0;
      neg_b_q <= 1'b0;
      bzero_q <= 1'b0;
      off_q   <= 1'b0;
      a_q     <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          op_q    <= op_in;
          neg_a_q <= sa;
          neg_b_q <= sb;
          bzero_q <= (b_i == '0);
          off_q   <= in_off;
          a_q     <= a_i;
          cnt_q   <= in_div ? CW'(DIV_CYC) : CW'(MUL_CYC);
          st_q    <= in_off ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q - CW'(1);
          if (last_run) begin
            if (op_is_div(op_q)) begin
              st_q <= ST_FIN;
            end else begin
              st_q   <= ST_IDLE;
              res_q  <= mul_res;
              done_q <= 1'b1;
            end
          end
        end
        default: begin
          st_q   <= ST_IDLE;
          res_q  <= off_q ? '0 : div_res;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;

  // ---------------- assertions ----------------
  logic [CW-1:0] lat_q;  // edges since the accepting edge, for latency checks
  always_ff @(posedge clk) begin
    if (!rst_n)             lat_q <= '0;
    else if (accept)        lat_q <= '0;
    else if (lat_q != '1)   lat_q <= lat_q + CW'(1);
  end

  p_mul_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !op_is_div(op_q) && !off_q) |-> (lat_q == CW'(MUL_CYC)))
    else $error("multiply latency");

  p_div_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_is_div(op_q) && !off_q) |-> (lat_q == CW'(DIV_CYC + 1)))
    else $error("divide latency");

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  p_result_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o))
    else $error("result moved without done");

  p_disabled_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && off_q) |-> (result_o == '0 && lat_q == CW'(1)))
    else $error("disabled path result");

endmodule

// File: tb/iter_muldiv_tb_top.sv
module iter_muldiv_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        st_m = 1'b0, st_a = 1'b0;
  logic [2:0]  op_m = '0, op_a = '0;
  logic [31:0] a_m = '0, b_m = '0, a_a = '0, b_a = '0;
  logic        busy_m, done_m, busy_a, done_a;
  logic [31:0] res_m, res_a;

  int n_chk = 0;
  int n_bad = 0;

  iter_muldiv dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(st_m), .op_i(op_m), .a_i(a_m), .b_i(b_m),
    .busy_o(busy_m), .done_o(done_m), .result_o(res_m));

  iter_muldiv #(.MUL_STEPS(4), .DIV_STEPS(8), .MUL_EN(1'b0), .DIV_EN(1'b1)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .start_i(st_a), .op_i(op_a), .a_i(a_a), .b_i(b_a),
    .busy_o(busy_a), .done_o(done_a), .result_o(res_a));

  task automatic check(input string req, input bit ok, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
    longint x;
    longint unsigned u;
    logic ovf;
    ovf = (a == 32'h8000_0000) && (b == 32'hFFFF_FFFF);
    case (op)
      3'd0: begin u = {32'b0, a} * {32'b0, b}; return u[31:0]; end
      3'd1: begin x = longint'($signed(a)) * longint'($signed(b)); return x[63:32]; end
      3'd2: begin x = longint'($signed(a)) * longint'({32'b0, b}); return x[63:32]; end
      3'd3: begin u = {32'b0, a} * {32'b0, b}; return u[63:32]; end
      3'd4: return (b == 0) ? 32'hFFFF_FFFF : ovf ? a : 32'($signed(a) / $signed(b));
      3'd5: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      3'd6: return (b == 0) ? a : ovf ? 32'd0 : 32'($signed(a) % $signed(b));
      default: return (b == 0) ? a : a % b;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [31:0] a,
                                   input logic [31:0] b);
    if (op[2] && b == 0) return "R5";
    if ((op == 3'd4 || op == 3'd6) && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R6";
    if (op == 3'd0) return "R1";
    if (!op[2]) return "R2";
    if (!op[1]) return "R3";
    return "R4";
  endfunction

  function automatic logic [31:0] rnd_val();
    case ($urandom % 6)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return $urandom % 16;
      default: return $urandom;
    endcase
  endfunction

  // alt: use dut_alt_i; poke: raise start mid-run on the main copy (R10)
  task automatic run_op(input bit alt, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input bit poke);
    int cyc;
    int exp_lat;
    logic [31:0] exp_res, got, held;
    logic d;
    @(negedge clk);
    if (alt) begin st_a = 1; op_a = op; a_a = a; b_a = b; end
    else     begin st_m = 1; op_m = op; a_m = a; b_m = b; end
    @(negedge clk);
    st_a = 0; st_m = 0;
    cyc = 0;
    d = alt ? done_a : done_m;
    while (!d && cyc < 100) begin
      if (poke && cyc == 2) begin st_m = 1; op_m = 3'd3; a_m = ~a; b_m = b ^ 32'h5A5A_0001; end
      @(negedge clk);
      st_m = 0;
      cyc++;
      d = alt ? done_a : done_m;
    end
    got = alt ? res_a : res_m;
    if (alt) begin
      exp_lat = op[2] ? 32 / 8 + 1 : 1;
      exp_res = op[2] ? model(op, a, b) : 32'd0;
    end else begin
      exp_lat = op[2] ? 33 : 32;
      exp_res = model(op, a, b);
    end
    if (alt && !op[2]) check("R12 disabled result", d && got == 0, got, 0);
    else if (poke) check("R10 busy start ignored", d && got == exp_res, got, exp_res);
    else check(tag_of(op, a, b), d && got == exp_res, got, exp_res);
    if (alt && !op[2]) check("R12 disabled latency", cyc == 1, cyc, 1);
    else if (op[2]) check("R8 divide latency", cyc == exp_lat, cyc, exp_lat);
    else check("R7 multiply latency", cyc == exp_lat, cyc, exp_lat);
    held = got;
    @(negedge clk);
    d = alt ? done_a : done_m;
    got = alt ? res_a : res_m;
    check("R9 done one cycle, result held", !d && got == held, got, held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 1'b0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset busy/done", !busy_m && !done_m && !busy_a && !done_a, {busy_m, done_m}, 0);
    check("R11 reset result", res_m == 0 && res_a == 0, res_m, 0);
    rst_n = 1;
    @(negedge clk);

    // directed corners
    run_op(0, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);  // R1
    run_op(0, 3'd1, 32'h8000_0000, 32'h8000_0000, 0);  // R2
    run_op(0, 3'd1, 32'h8000_0000, 32'hFFFF_FFFF, 0);  // R2
    run_op(0, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);  // R2
    run_op(0, 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);  // R2
    run_op(0, 3'd4, 32'hFFFF_FFF9, 32'd2, 0);          // R3 -7/2 = -3
    run_op(0, 3'd6, 32'hFFFF_FFF9, 32'd2, 0);          // R4 -7%2 = -1
    run_op(0, 3'd7, 32'd100, 32'd7, 0);                // R4
    for (int k = 4; k < 8; k++) run_op(0, 3'(k), 32'h8765_4321, 32'd0, 0);  // R5
    run_op(0, 3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 0);  // R6
    run_op(0, 3'd6, 32'h8000_0000, 32'hFFFF_FFFF, 0);  // R6
    run_op(0, 3'd5, 32'hDEAD_BEEF, 32'd13, 1);         // R10 divide
    run_op(0, 3'd1, 32'h1234_5678, 32'hF000_0001, 1);  // R10 multiply
    run_op(1, 3'd0, 32'd3, 32'd5, 0);                  // R12
    run_op(1, 3'd2, 32'hFFFF_FFFF, 32'd5, 0);          // R12
    run_op(1, 3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 0);  // R6 on alt build
    run_op(1, 3'd7, 32'd9, 32'd0, 0);                  // R5 on alt build

    // constrained random
    for (int k = 0; k < 120; k++) run_op(0, 3'($urandom % 8), rnd_val(), rnd_val(), 0);
    for (int k = 0; k < 40; k++)  run_op(1, 3'($urandom % 8), rnd_val(), rnd_val(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule